// File: doc/BRIEF.md
# Output Bank Clock Divider with Safe Gating

This block drives one bank of four clock outputs from a single reference clock that has already been selected upstream. One shared divider either passes the reference straight through or divides it by any integer from 2 to 511. The result fans out to every output of the bank, so all four run at the same frequency and phase. Each output has a true output, a complementary output and a drive-enable for its pad. A drive-enable of 0 means the pad floats (high impedance).

There are three levels of gating. The asynchronous global output-enable pin and the bank-wide disable bit are first synchronised. They are then applied only at a period boundary, while the divided clock is low, so they never shorten a pulse. A per-output disable bit and a per-output power-down bit act at once and may clip a pulse. The intended safe sequence is to disable the bank, change the per-output bit, then re-enable the bank. Odd ratios keep a 50% duty cycle by adding a copy of the divided clock retimed on the falling reference edge.

Top module: `clk_bank_div`

## Requirements
- R1: For a ratio field value N with 2 ≤ N ≤ 511 (9-bit field), every enabled output has a period of exactly N reference cycles.
- R2: Each output pulse is high for exactly N reference half-cycles, for even and for odd N.
- R3: A ratio field value of 0 or 1 selects bypass. Each enabled output then follows the reference clock: high in the first half of each reference cycle, low in the second.
- R4: A new ratio written while the bank runs takes effect only at the end of the current output period. No pulse of any other width is emitted.
- R5: Asserting or releasing the bank disable never produces a pulse shorter than N half-cycles. Once the change has been applied, a disabled bank holds every true output low.
- R6: With the global enable pin low, every drive-enable falls, and only after the last full pulse. True outputs stay low. With the pin high, the drive-enable of each output that is not powered down is 1. No true output is high while its drive-enable is 0.
- R7: A per-output disable bit forces that true output low immediately. Its drive-enable stays 1, and the other outputs keep toggling.
- R8: A per-output power-down bit forces that drive-enable to 0 and its true output low, whatever the global enable pin is doing.
- R9: The complementary output is the inverse of the true output. The one exception is an output with both its single-ended-mode bit and its in-phase bit set: there the complementary output equals the true output.
- R10: While reset is low, every true output and every drive-enable is 0.
- R11: All four true outputs of an enabled bank are identical at every instant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Selected reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_pin | input | 1 | Asynchronous global output enable, 1 = enabled |
| bank_dis | input | 1 | Bank-wide glitch-free disable, 1 = disabled |
| cfg_ratio | input | RATIO_W | Divide ratio; 0 or 1 = bypass |
| out_dis | input | NOUT | Per-output immediate disable, 1 = held low |
| out_pd | input | NOUT | Per-output power-down, 1 = floated |
| cmos_sel | input | NOUT | Per-output single-ended mode |
| cmos_inph | input | NOUT | In single-ended mode, 1 = complement in phase |
| q | output | NOUT | True clock outputs |
| qn | output | NOUT | Complementary clock outputs |
| drv_en | output | NOUT | Pad drive enable, 0 = high impedance |

## Verification
The assertions take the ratio field to be quasi-static: it may change while the bank runs between two divide settings. A move into or out of bypass happens only with the bank disabled. They also take the enable pin and disable bit to be held for at least as long as the synchroniser chain, so the period-boundary register and the half-cycle bypass register see the same request. The bench follows both rules. Every ratio sweep step disables the bank, waits past the old period, loads the new ratio and re-enables. Live ratio changes only happen from one even or odd ratio to another.

// File: rtl/cbd_pkg.sv
`timescale 1ns/1ps
// Shared types for the output-bank divider.
// Assumes: nothing; pure type definitions.
package cbd_pkg;

    // Operating mode of the divider, decoded from the ratio field.
    typedef enum logic [1:0] {
        DM_BYPASS = 2'd0,
        DM_EVEN   = 2'd1,
        DM_ODD    = 2'd2
    } div_mode_t;

endpackage

// File: rtl/cbd_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for slow asynchronous control levels.
// Assumes: inputs are levels held longer than STAGES clock cycles.
module cbd_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the sampled levels through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/cbd_divider.sv
`timescale 1ns/1ps
// Shared bank divider: bypass, even or odd integer division with 50% duty.
// Enable and drive requests are applied only at period boundaries in divide
// mode and only while the reference is low in bypass mode, so no pulse is cut.
// Assumes: en_req/oe_req are synchronous to clk_ref; cfg_ratio is quasi-static
// and moves into or out of bypass only while the bank is disabled.
module cbd_divider
    import cbd_pkg::*;
#(
    parameter int RATIO_W = 9
) (
    input  logic               clk_ref,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic               en_req,
    input  logic               oe_req,
    output logic               div_clk,
    output logic               oe_app
);
    localparam int                 SUM_W     = RATIO_W + 1;
    localparam logic [RATIO_W-1:0] RATIO_ONE = RATIO_W'(1);
    localparam logic [RATIO_W-1:0] RATIO_RST = RATIO_W'(2);

    // Number of rising-edge cycles the positive-phase flop stays high.
    function automatic logic [RATIO_W-1:0] high_len(input logic [RATIO_W-1:0] r);
        logic [SUM_W-1:0] s;
        s = {1'b0, r} + SUM_W'(1);
        return s[SUM_W-1:1];
    endfunction

    // Decode the operating mode from a ratio value.
    function automatic div_mode_t mode_of(input logic [RATIO_W-1:0] r);
        if (r <= RATIO_ONE) return DM_BYPASS;
        else if (r[0])      return DM_ODD;
        else                return DM_EVEN;
    endfunction

    logic [RATIO_W-1:0] ratio_cur, ratio_nxt;
    logic [RATIO_W-1:0] cnt, cnt_nxt;
    div_mode_t          mode_cur, mode_nxt;
    logic               wrap;
    logic               hi_nxt;
    logic               en_div, en_nxt;
    logic               oe_div, oe_nxt;
    logic               q_pos;
    logic               q_neg;
    logic               byp_en, byp_oe;

    // Next-state of counter, ratio and period-boundary enables.
    always_comb begin
        mode_cur  = mode_of(ratio_cur);
        wrap      = (mode_cur == DM_BYPASS) || (cnt == ratio_cur - RATIO_ONE);
        ratio_nxt = wrap ? cfg_ratio : ratio_cur;
        cnt_nxt   = wrap ? '0 : cnt + RATIO_ONE;
        en_nxt    = wrap ? en_req : en_div;
        oe_nxt    = wrap ? oe_req : oe_div;
        mode_nxt  = mode_of(ratio_nxt);
        hi_nxt    = cnt_nxt < high_len(ratio_nxt);
    end

    // Rising-edge counter and gated positive-phase divided clock.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            ratio_cur <= RATIO_RST;
            cnt       <= '0;
            en_div    <= 1'b0;
            oe_div    <= 1'b0;
            q_pos     <= 1'b0;
        end else begin
            ratio_cur <= ratio_nxt;
            cnt       <= cnt_nxt;
            en_div    <= en_nxt;
            oe_div    <= oe_nxt;
            q_pos     <= hi_nxt && en_nxt && (mode_nxt != DM_BYPASS);
        end
    end

    // Falling-edge retime for odd duty and bypass gate updates while clock is low.
    always_ff @(negedge clk_ref) begin
        if (!rst_n) begin
            q_neg  <= 1'b0;
            byp_en <= 1'b0;
            byp_oe <= 1'b0;
        end else begin
            q_neg  <= q_pos;
            byp_en <= en_req;
            byp_oe <= oe_req;
        end
    end

    // Select the divided clock and the drive request for the active mode.
    always_comb begin
        unique case (mode_cur)
            DM_BYPASS: begin
                div_clk = clk_ref & byp_en;
                oe_app  = byp_oe;
            end
            DM_ODD: begin
                div_clk = q_pos & q_neg;
                oe_app  = oe_div;
            end
            default: begin
                div_clk = q_pos;
                oe_app  = oe_div;
            end
        endcase
    end

    // Checker: length of the current high phase of the positive flop.
    logic [RATIO_W-1:0] hi_len;
    always_ff @(posedge clk_ref) begin
        if (!rst_n)     hi_len <= '0;
        else if (q_pos) hi_len <= hi_len + RATIO_ONE;
        else            hi_len <= '0;
    end

    assert_count_bound_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (mode_cur != DM_BYPASS) |-> (cnt < ratio_cur));

    assert_half_high_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(q_pos) |-> (hi_len == high_len(ratio_cur)));

    assert_enable_safe_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (en_div != $past(en_div)) |-> !$past(q_pos));

    assert_oe_rise_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(oe_div) |-> $past(oe_req));

    assert_oe_fall_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(oe_div) |-> !$past(oe_req));

endmodule

// File: rtl/cbd_fanout.sv
`timescale 1ns/1ps
// Fans the divided clock out to the bank outputs with per-output gating,
// complement phase selection and pad drive enables.
// Assumes: div_clk and oe_app come from the glitch-free divider; per-output
// bits may change at any time and are allowed to clip a pulse.
module cbd_fanout #(
    parameter int NOUT = 4
) (
    input  logic            clk_ref,
    input  logic            rst_n,
    input  logic            div_clk,
    input  logic            oe_app,
    input  logic [NOUT-1:0] out_dis,
    input  logic [NOUT-1:0] out_pd,
    input  logic [NOUT-1:0] cmos_sel,
    input  logic [NOUT-1:0] cmos_inph,
    output logic [NOUT-1:0] q,
    output logic [NOUT-1:0] qn,
    output logic [NOUT-1:0] drv_en
);
    for (genvar i = 0; i < NOUT; i++) begin : g_out
        logic live;
        logic same_phase;

        // Direct per-output gating of the shared divided clock.
        always_comb begin
            live       = div_clk & ~out_dis[i] & ~out_pd[i];
            same_phase = cmos_sel[i] & cmos_inph[i];
        end

        assign q[i]      = live;
        assign qn[i]     = same_phase ? live : ~live;
        assign drv_en[i] = oe_app & ~out_pd[i];

        assert_drive_when_live_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
            q[i] |-> drv_en[i]);
    end

endmodule

// File: rtl/clk_bank_div.sv
`timescale 1ns/1ps
// Output bank: synchronises the global enable pin and bank disable bit,
// divides the reference and fans it out to NOUT outputs.
// Assumes: clk_ref is the already-selected reference; reset is synchronous.
module clk_bank_div #(
    parameter int RATIO_W     = 9,
    parameter int NOUT        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_ref,
    input  logic               rst_n,
    input  logic               oe_pin,
    input  logic               bank_dis,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic [NOUT-1:0]    out_dis,
    input  logic [NOUT-1:0]    out_pd,
    input  logic [NOUT-1:0]    cmos_sel,
    input  logic [NOUT-1:0]    cmos_inph,
    output logic [NOUT-1:0]    q,
    output logic [NOUT-1:0]    qn,
    output logic [NOUT-1:0]    drv_en
);
    logic [1:0] ctl_raw, ctl_sync;
    logic       en_req, oe_req;
    logic       div_clk, oe_app;

    assign ctl_raw = {oe_pin, bank_dis};

    cbd_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_sync)
    );

    // Bank runs only when globally enabled and not bank-disabled.
    always_comb begin
        oe_req = ctl_sync[1];
        en_req = ctl_sync[1] & ~ctl_sync[0];
    end

    cbd_divider #(.RATIO_W(RATIO_W)) u_div (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .cfg_ratio (cfg_ratio),
        .en_req    (en_req),
        .oe_req    (oe_req),
        .div_clk   (div_clk),
        .oe_app    (oe_app)
    );

    cbd_fanout #(.NOUT(NOUT)) u_fan (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .div_clk   (div_clk),
        .oe_app    (oe_app),
        .out_dis   (out_dis),
        .out_pd    (out_pd),
        .cmos_sel  (cmos_sel),
        .cmos_inph (cmos_inph),
        .q         (q),
        .qn        (qn),
        .drv_en    (drv_en)
    );

endmodule

// File: tb/sim_clk_bank_div.sv
`timescale 1ns/1ps
// Directed bench for the output bank divider; one task per scenario.
module sim_clk_bank_div;
    localparam int RW = 9;
    localparam int NO = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          oe_pin = 1'b0;
    logic          bank_dis = 1'b0;
    logic [RW-1:0] cfg_ratio = RW'(2);
    logic [NO-1:0] out_dis = '0, out_pd = '0, cmos_sel = '0, cmos_inph = '0;
    logic [NO-1:0] q, qn, drv_en;
    int            n_chk = 0, n_bad = 0;
    int            cur_ratio = 2;

    always #2.5 clk = ~clk;

    clk_bank_div #(.RATIO_W(RW), .NOUT(NO)) u0 (
        .clk_ref(clk), .rst_n(rst_n), .oe_pin(oe_pin), .bank_dis(bank_dis),
        .cfg_ratio(cfg_ratio), .out_dis(out_dis), .out_pd(out_pd),
        .cmos_sel(cmos_sel), .cmos_inph(cmos_inph),
        .q(q), .qn(qn), .drv_en(drv_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic half_step();
        @(clk);
        #1;
    endtask

    task automatic cycles(input int n);
        repeat (2 * n) half_step();
    endtask

    // Measure period and high time of one output, in half-cycles.
    task automatic measure(input int idx, input int n, input string req);
        int first = -1, second = -1, highs = 0;
        bit prev, cur;
        half_step();
        prev = q[idx];
        for (int k = 0; k < 8 * n + 16 && second < 0; k++) begin
            half_step();
            cur = q[idx];
            if (!prev && cur) begin
                if (first < 0) first = k;
                else second = k;
            end
            if (first >= 0 && second < 0 && cur) highs++;
            prev = cur;
        end
        chk(second >= 0 && (second - first) == 2 * n, {req, " period"}, second - first, 2 * n);
        chk(highs == n, {req, " high time"}, highs, n);
    endtask

    // Watch output 0 and count complete pulses whose width is neither w1 nor w2.
    task automatic watch(input int w1, input int w2, input int halves,
                         output int pulses, output int bad);
        bit prev, cur;
        int rise_k = -1;
        pulses = 0;
        bad = 0;
        half_step();
        prev = q[0];
        for (int k = 0; k < halves; k++) begin
            half_step();
            cur = q[0];
            if (!prev && cur) rise_k = k;
            if (prev && !cur && rise_k >= 0) begin
                pulses++;
                if ((k - rise_k) != w1 && (k - rise_k) != w2) bad++;
            end
            prev = cur;
        end
    endtask

    // Count samples of output idx that are high over a window.
    task automatic count_high(input int idx, input int halves, output int highs);
        highs = 0;
        for (int k = 0; k < halves; k++) begin
            half_step();
            if (q[idx]) highs++;
        end
    endtask

    // Load a new ratio safely: disable the bank, change, re-enable.
    task automatic load_ratio(input int n);
        int big;
        bank_dis = 1'b1;
        cycles(cur_ratio + 8);
        cfg_ratio = RW'(n);
        cycles(cur_ratio + 4);
        bank_dis = 1'b0;
        big = (n < 2) ? 1 : n;
        cycles(2 * big + 8);
        cur_ratio = big;
    endtask

    task automatic t_reset();
        oe_pin = 1'b1;
        cycles(4);
        chk(q == '0, "R10 outputs in reset", int'(q), 0);
        chk(drv_en == '0, "R10 drive enables in reset", int'(drv_en), 0);
        rst_n = 1'b1;
        cycles(12);
        chk(drv_en == 4'hF, "R6 drive enables after enable", int'(drv_en), 15);
    endtask

    task automatic t_ratios();
        int list[8] = '{2, 3, 4, 7, 8, 1, 0, 511};
        foreach (list[j]) begin
            load_ratio(list[j]);
            if (list[j] < 2) measure(0, 1, "R3 bypass");
            else if (list[j][0]) measure(3, list[j], "R1 R2 odd ratio");
            else measure(1, list[j], "R1 R2 even ratio");
        end
        load_ratio(4);
    endtask

    task automatic t_live_switch();
        int pulses, bad;
        fork
            watch(4, 5, 120, pulses, bad);
            begin
                cycles(9);
                cfg_ratio = RW'(5);
            end
        join
        chk(bad == 0, "R4 no odd-width pulse on live ratio change", bad, 0);
        cur_ratio = 5;
        measure(2, 5, "R4 new ratio in force");
    endtask

    task automatic t_bank_gate(input int n);
        int pulses, bad, highs;
        load_ratio(n);
        fork
            watch(n, n, 8 * n + 160, pulses, bad);
            begin
                cycles(7);
                bank_dis = 1'b1;
                cycles(2 * n + 9);
                bank_dis = 1'b0;
                cycles(n + 3);
                bank_dis = 1'b1;
                cycles(3);
                bank_dis = 1'b0;
            end
        join
        chk(bad == 0 && pulses > 0, "R5 bank gate keeps full pulses", bad, 0);
        bank_dis = 1'b1;
        cycles(n + 6);
        count_high(0, 4 * n + 8, highs);
        chk(highs == 0, "R5 disabled bank holds low", highs, 0);
        bank_dis = 1'b0;
        cycles(2 * n + 8);
    endtask

    task automatic t_global_oe();
        int pulses, bad, highs;
        load_ratio(3);
        fork
            watch(3, 3, 60, pulses, bad);
            begin
                cycles(8);
                oe_pin = 1'b0;
            end
        join
        chk(bad == 0, "R6 enable pin drop keeps full pulses", bad, 0);
        chk(drv_en == '0, "R6 all outputs float", int'(drv_en), 0);
        count_high(1, 30, highs);
        chk(highs == 0, "R6 no clock while floating", highs, 0);
        oe_pin = 1'b1;
        cycles(12);
        chk(drv_en == 4'hF, "R6 drive restored", int'(drv_en), 15);
        measure(0, 3, "R6 clock restored");
    endtask

    task automatic t_out_dis();
        int h0, h1;
        load_ratio(2);
        out_dis = 4'b0010;
        fork
            count_high(0, 20, h0);
            count_high(1, 20, h1);
        join
        chk(h1 == 0, "R7 disabled output held low", h1, 0);
        chk(h0 == 10, "R7 neighbour keeps toggling", h0, 10);
        chk(drv_en[1] == 1'b1, "R7 disabled output still driven", int'(drv_en[1]), 1);
        out_dis = '0;
    endtask

    task automatic t_power_down();
        int h2;
        out_pd = 4'b0100;
        half_step();
        chk(drv_en == 4'b1011, "R8 power-down floats one output", int'(drv_en), 11);
        count_high(2, 20, h2);
        chk(h2 == 0, "R8 powered-down output low", h2, 0);
        oe_pin = 1'b0;
        cycles(8);
        oe_pin = 1'b1;
        cycles(8);
        chk(drv_en == 4'b1011, "R8 power-down holds through enable pulse", int'(drv_en), 11);
        out_pd = '0;
        half_step();
    endtask

    task automatic t_complement();
        bit ok0 = 1, ok1 = 1, ok2 = 1, ok3 = 1;
        cmos_sel  = 4'b0110;
        cmos_inph = 4'b1010;
        for (int k = 0; k < 16; k++) begin
            half_step();
            if (qn[0] != ~q[0]) ok0 = 0;
            if (qn[1] != q[1])  ok1 = 0;
            if (qn[2] != ~q[2]) ok2 = 0;
            if (qn[3] != ~q[3]) ok3 = 0;
        end
        chk(ok0, "R9 differential complement", int'(ok0), 1);
        chk(ok1, "R9 single-ended in phase", int'(ok1), 1);
        chk(ok2, "R9 single-ended inverted", int'(ok2), 1);
        chk(ok3, "R9 in-phase bit ignored outside single-ended", int'(ok3), 1);
        cmos_sel  = '0;
        cmos_inph = '0;
    endtask

    task automatic t_all_same();
        bit ok = 1;
        int seen = 0;
        load_ratio(7);
        for (int k = 0; k < 60; k++) begin
            half_step();
            if (q != {NO{q[0]}}) ok = 0;
            if (q[0]) seen++;
        end
        chk(ok && seen > 0, "R11 outputs identical", int'(q), int'({NO{q[0]}}));
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        t_reset();
        t_ratios();
        t_live_switch();
        t_bank_gate(4);
        t_bank_gate(5);
        t_bank_gate(1);
        t_global_oe();
        t_out_dis();
        t_power_down();
        t_complement();
        t_all_same();
        finish_run();
    end

endmodule